// File: doc/BRIEF.md
# Channel Window Comparator Interrupt

This block watches the stream of conversion results leaving a multi-channel analog-to-digital converter. Each result arrives with a valid strobe, the index of the channel it came from and a 10-bit code. If that channel is selected in a target mask, the code is tested against one window made of a lower and an upper bound. All channels share this window.

A mode bit picks the event. In outside mode a hit is a code below the lower bound or above the upper bound. In inside mode a hit is a code between the bounds, both included. A hit sets a sticky comparator flag, which software clears by a one-cycle clear strobe. When the interrupt enable is set, each hit also produces a one-clock interrupt pulse. The bounds, the mask, the mode and the enable are loaded through separate write strobes. Conversion timing and bus decoding are handled outside this block.

Top module: `chan_window_irq`

## Requirements
- R1: After reset, cmpFlag and cmpIrq are 0, both bounds are 0, the mode is outside mode (0), the enable is 0 and the target mask is 0, so no result can hit until the mask is written.
- R2: With mode 0, a targeted result is a hit when result < lower or result > upper; a result equal to either bound is not a hit.
- R3: With mode 1, a targeted result is a hit when lower <= result <= upper, with both bounds inclusive.
- R4: A result is compared only if bit i of the target mask is 1, where i is the channel index on resChan (bit 0 = channel 0). An index of NUM_CH or above is never compared.
- R5: Results are evaluated one by one, on every clock where resValid is 1. Nothing is evaluated while resValid is 0.
- R6: A hit sampled at a clock edge sets cmpFlag after that edge, and cmpFlag stays set until it is cleared.
- R7: flagClr clears cmpFlag after the edge that samples it. If a hit is sampled at the same edge, cmpFlag stays 1.
- R8: When the enable is 1, each hit produces a cmpIrq pulse exactly one clock wide after the sampling edge, also when cmpFlag is already set. When the enable is 0, no pulse is produced, but the flag still sets.
- R9: A configuration write sampled at an edge applies to results sampled at later edges. If lower > upper, mode 1 never hits and mode 0 hits on every targeted result, with no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | Conversion result valid strobe |
| resChan | input | IDX_W (3) | Channel index of the result |
| resData | input | DATA_W (10) | Conversion result code |
| loWr | input | 1 | Load strobe for the lower bound |
| hiWr | input | 1 | Load strobe for the upper bound |
| boundData | input | DATA_W (10) | Bound value for loWr / hiWr |
| maskWr | input | 1 | Load strobe for the target mask |
| maskData | input | NUM_CH (6) | New target mask |
| modeWr | input | 1 | Load strobe for the mode bit |
| modeData | input | 1 | 0 = outside mode, 1 = inside mode |
| ienWr | input | 1 | Load strobe for the interrupt enable |
| ienData | input | 1 | New interrupt enable |
| flagClr | input | 1 | Clear strobe for the comparator flag |
| cmpFlag | output | 1 | Sticky comparator flag |
| cmpIrq | output | 1 | One-clock comparator interrupt pulse |

## Verification
The bench uses the default parameters: six channels, 10-bit codes and a 3-bit channel index. With a 3-bit index the bench can drive codes 6 and 7, which name no channel. With 10-bit codes it can place results exactly on each bound, one step away from each bound, and at 0 and 1023. The bench also programs an inverted window, with lower above upper, and checks both modes against it. It drives a hit in the same cycle as a clear, and several hits in a row while the flag is already set.

// File: rtl/cmpwin_pkg.sv
package cmpwin_pkg;
  // Result of evaluating one conversion against the window.
  typedef struct packed {
    logic eval;  // a targeted result was evaluated this cycle
    logic hit;   // the evaluation matched the selected mode
  } cmpEvt_t;
endpackage

// File: rtl/cmpwin_datapath.sv
module cmpwin_datapath
  import cmpwin_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resValid,
  input  logic [IDX_W-1:0]  resChan,
  input  logic [DATA_W-1:0] resData,
  input  logic              loWr,
  input  logic              hiWr,
  input  logic [DATA_W-1:0] boundData,
  input  logic              maskWr,
  input  logic [NUM_CH-1:0] maskData,
  input  logic              modeWr,
  input  logic              modeData,
  output cmpEvt_t           evt
);
  localparam int CMP_IDX_W = IDX_W + 1;

  logic [DATA_W-1:0] loBound, hiBound;
  logic [NUM_CH-1:0] tgtMask;
  logic              insideMode;
  logic [NUM_CH-1:0] chanSel;
  logic              evalNow, belowLo, aboveHi, inWin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loBound    <= '0;
      hiBound    <= '0;
      tgtMask    <= '0;
      insideMode <= 1'b0;
    end else begin
      if (loWr)   loBound    <= boundData;
      if (hiWr)   hiBound    <= boundData;
      if (maskWr) tgtMask    <= maskData;
      if (modeWr) insideMode <= modeData;
    end
  end

  // One select term per channel: valid, index match and mask bit.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign chanSel[i] = resValid && (resChan == IDX_W'(i)) && tgtMask[i];
  end

  always_comb begin
    evalNow  = |chanSel;
    belowLo  = resData < loBound;
    aboveHi  = resData > hiBound;
    inWin    = !belowLo && !aboveHi;
    evt.eval = evalNow;
    evt.hit  = evalNow && (insideMode ? inWin : !inWin);
  end

  // R5: no evaluation without a valid strobe
  assert_no_eval_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !evt.eval);

  // R4: indices beyond the channel count are never compared
  assert_no_eval_bad_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, resChan} >= CMP_IDX_W'(NUM_CH)) |-> !evt.eval);

  // R9: inverted window in inside mode never hits
  assert_inverted_inside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loBound > hiBound && insideMode) |-> !evt.hit);

  // R9: inverted window in outside mode hits every evaluated result
  assert_inverted_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loBound > hiBound && !insideMode && evt.eval) |-> evt.hit);
endmodule

// File: rtl/cmpwin_ctrl.sv
module cmpwin_ctrl
  import cmpwin_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cmpEvt_t evt,
  input  logic    ienWr,
  input  logic    ienData,
  input  logic    flagClr,
  output logic    cmpFlag,
  output logic    cmpIrq
);
  logic ienReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ienReg  <= 1'b0;
      cmpFlag <= 1'b0;
      cmpIrq  <= 1'b0;
    end else begin
      if (ienWr) ienReg <= ienData;
      // a new hit takes priority over a clear in the same cycle
      cmpFlag <= evt.hit || (cmpFlag && !flagClr);
      cmpIrq  <= evt.hit && ienReg;
    end
  end

  // R6: a hit sets the flag at the next edge
  assert_hit_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt.hit |=> cmpFlag);

  // R7: a clear without a concurrent hit drops the flag
  assert_clear_drops_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flagClr && !evt.hit) |=> !cmpFlag);

  // R6: flag rises only because of a hit
  assert_flag_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpFlag) |-> $past(evt.hit));

  // R8: an interrupt pulse traces back to an evaluated hit under enable
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmpIrq |-> ($past(evt.eval) && $past(evt.hit) && $past(ienReg)));

  // R8: an enabled hit always pulses
  assert_irq_follows_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.hit && ienReg) |=> cmpIrq);

  // R8: pulse is accompanied by the flag
  assert_irq_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmpIrq |-> cmpFlag);
endmodule

// File: rtl/chan_window_irq.sv
module chan_window_irq
  import cmpwin_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 6,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resValid,
  input  logic [IDX_W-1:0]  resChan,
  input  logic [DATA_W-1:0] resData,
  input  logic              loWr,
  input  logic              hiWr,
  input  logic [DATA_W-1:0] boundData,
  input  logic              maskWr,
  input  logic [NUM_CH-1:0] maskData,
  input  logic              modeWr,
  input  logic              modeData,
  input  logic              ienWr,
  input  logic              ienData,
  input  logic              flagClr,
  output logic              cmpFlag,
  output logic              cmpIrq
);
  cmpEvt_t evt;

  cmpwin_datapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .resValid(resValid), .resChan(resChan), .resData(resData),
    .loWr(loWr), .hiWr(hiWr), .boundData(boundData),
    .maskWr(maskWr), .maskData(maskData),
    .modeWr(modeWr), .modeData(modeData),
    .evt(evt)
  );

  cmpwin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .ienWr(ienWr), .ienData(ienData), .flagClr(flagClr),
    .cmpFlag(cmpFlag), .cmpIrq(cmpIrq)
  );

  // R1: outputs idle right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!cmpFlag && !cmpIrq));
endmodule

// File: tb/sim_chan_window_irq.sv
`timescale 1ns/1ps
module sim_chan_window_irq;
  localparam int DATA_W = 10;
  localparam int NUM_CH = 6;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              resValid = 0, loWr = 0, hiWr = 0, maskWr = 0;
  logic              modeWr = 0, modeData = 0, ienWr = 0, ienData = 0, flagClr = 0;
  logic [IDX_W-1:0]  resChan = '0;
  logic [DATA_W-1:0] resData = '0, boundData = '0;
  logic [NUM_CH-1:0] maskData = '0;
  logic              cmpFlag, cmpIrq;

  chan_window_irq #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .resValid(resValid), .resChan(resChan), .resData(resData),
    .loWr(loWr), .hiWr(hiWr), .boundData(boundData),
    .maskWr(maskWr), .maskData(maskData),
    .modeWr(modeWr), .modeData(modeData),
    .ienWr(ienWr), .ienData(ienData), .flagClr(flagClr),
    .cmpFlag(cmpFlag), .cmpIrq(cmpIrq)
  );

  typedef struct {
    logic  flag;
    logic  irq;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference state, built from the requirements
  logic [DATA_W-1:0] mLo = '0, mHi = '0;
  logic [NUM_CH-1:0] mMask = '0;
  logic              mMode = 0, mIen = 0, mFlag = 0;

  // staged stimulus for the next cycle
  logic              sV = 0, sLoW = 0, sHiW = 0, sMaskW = 0, sModeW = 0, sMode = 0;
  logic              sIenW = 0, sIen = 0, sClr = 0;
  logic [IDX_W-1:0]  sCh = '0;
  logic [DATA_W-1:0] sD = '0, sB = '0;
  logic [NUM_CH-1:0] sMask = '0;

  task automatic step(input string tag);
    logic hit;
    exp_t e;
    @(negedge clk);
    resValid = sV; resChan = sCh; resData = sD;
    loWr = sLoW; hiWr = sHiW; boundData = sB;
    maskWr = sMaskW; maskData = sMask;
    modeWr = sModeW; modeData = sMode;
    ienWr = sIenW; ienData = sIen; flagClr = sClr;
    hit = sV && (int'(sCh) < NUM_CH) && mMask[sCh] &&
          (mMode ? (sD >= mLo && sD <= mHi) : (sD < mLo || sD > mHi));
    mFlag = hit || (mFlag && !sClr);
    e.flag = mFlag;
    e.irq  = hit && mIen;
    e.tag  = tag;
    expQ.push_back(e);
    if (sLoW)   mLo   = sB;
    if (sHiW)   mHi   = sB;
    if (sMaskW) mMask = sMask;
    if (sModeW) mMode = sMode;
    if (sIenW)  mIen  = sIen;
    sV = 0; sLoW = 0; sHiW = 0; sMaskW = 0; sModeW = 0; sIenW = 0; sClr = 0;
  endtask

  task automatic result(input int ch, input int d, input string tag);
    sV = 1; sCh = IDX_W'(ch); sD = DATA_W'(d);
    step(tag);
  endtask

  task automatic setWindow(input int lo, input int hi);
    sLoW = 1; sB = DATA_W'(lo); step("cfg");
    sHiW = 1; sB = DATA_W'(hi); step("cfg");
  endtask

  task automatic setMode(input logic m);
    sModeW = 1; sMode = m; step("cfg");
  endtask

  task automatic clearFlag(input string tag);
    sClr = 1; step(tag);
  endtask

  // monitor: compare each expected item after the edge that produces it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nChecks++;
        if (cmpFlag !== e.flag || cmpIrq !== e.irq) begin
          nFails++;
          $display("FAIL %s: flag/irq actual %b/%b expected %b/%b",
                   e.tag, cmpFlag, cmpIrq, e.flag, e.irq);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible at the ports
    nChecks++;
    if (cmpFlag !== 1'b0 || cmpIrq !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: flag/irq actual %b/%b expected 0/0", cmpFlag, cmpIrq);
    end
    // R1, R4: mask is zero after reset, so an outside result on any channel is ignored
    result(0, 500, "R1 mask empty ch0");
    result(5, 1023, "R1 mask empty ch5");
    step("R1 idle");

    sIenW = 1; sIen = 1; step("cfg");
    sMaskW = 1; sMask = 6'b000101; step("cfg");
    setWindow(100, 200);

    // R2: outside mode
    result(0, 50, "R2 below lower");
    clearFlag("R7 clear");
    result(0, 150, "R2 inside no hit");
    result(0, 100, "R2 equal lower no hit");
    result(0, 200, "R2 equal upper no hit");
    result(0, 99, "R2 lower minus one");
    clearFlag("R7 clear");
    result(0, 201, "R2 upper plus one");
    clearFlag("R7 clear");
    result(2, 1023, "R2 max code ch2");
    clearFlag("R7 clear");
    // R4: untargeted and out-of-range channels
    result(1, 5, "R4 ch1 untargeted");
    result(6, 5, "R4 index 6");
    result(7, 1020, "R4 index 7");
    result(3, 0, "R4 ch3 untargeted");

    // R5: data in outside region but no valid strobe
    sV = 0; sCh = '0; sD = 10'd5; step("R5 no valid");
    step("R5 idle");

    // R3: inside mode, inclusive bounds
    setMode(1'b1);
    result(0, 100, "R3 equal lower hit");
    clearFlag("R7 clear");
    result(2, 200, "R3 equal upper hit");
    clearFlag("R7 clear");
    result(0, 99, "R3 below no hit");
    result(0, 201, "R3 above no hit");
    result(0, 150, "R3 middle hit");

    // R7: hit and clear together keep the flag; clear alone drops it
    sClr = 1; result(0, 160, "R7 hit with clear");
    clearFlag("R7 clear alone");

    // R8: back-to-back hits each pulse; flag stays
    result(0, 120, "R8 pulse one");
    result(2, 130, "R8 pulse two with flag set");
    result(0, 140, "R8 pulse three");
    step("R8 pulse ends");
    sIenW = 1; sIen = 0; step("cfg");
    clearFlag("R7 clear");
    result(0, 150, "R8 disabled flag only");
    step("R8 disabled idle");

    // R9: inverted window and config timing
    clearFlag("R7 clear");
    sIenW = 1; sIen = 1; step("cfg");
    setWindow(300, 100);
    result(0, 200, "R9 inverted inside no hit");
    result(0, 300, "R9 inverted inside at lower");
    result(0, 100, "R9 inverted inside at upper");
    setMode(1'b0);
    result(0, 200, "R9 inverted outside hit");
    clearFlag("R7 clear");
    result(2, 0, "R9 inverted outside zero");
    // R9: mask write applies only to later results
    sMaskW = 1; sMask = 6'b000000; sV = 1; sCh = '0; sD = 10'd0;
    step("R9 mask write same cycle uses old mask");
    result(0, 0, "R9 mask cleared later");

    repeat (4) step("drain");
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule